// File: doc/BRIEF.md
# IrDA Return-to-Zero Pulse Encoder

This block sits between the serial output of a UART transmitter and an infrared transmit pin. When encoding is switched on, every zero data bit is turned into a short return-to-zero pulse that starts when the bit starts. A one bit produces no pulse, so the line stays at its idle level for that whole bit. When encoding is switched off, the UART level passes straight through. The pulse length is set by a 4-bit count. That count is taken either in sixteenths of a bit period, using a 16x-baud tick, or in ticks of a fixed base clock, using a separate base tick that is independent of the baud rate. The pulse can be active high or active low.

A second output feeds the receive path of the UART. It carries either the external receive pin or, in loopback, the serial bit being transmitted. All configuration fields are captured on the bit-start strobe, together with the data bit. A pulse already running is therefore never shortened or stretched by a configuration write. Both outputs are registered.

Top module: `irda_rz_encoder`

## Requirements
- R1: When the enable captured at the last bit start is 0, `ir_tx_o` equals `ser_bit_i` from the previous clock cycle (no encoding).
- R2: When encoding is enabled and the captured data bit is 1, `ir_tx_o` stays at the idle level for the whole bit.
- R3: With encoding enabled, the captured data bit 0, width n>0 and `cfg_base_clk_i`=0, the pulse level appears on the edge where `bit_start_i` is high. It holds until the edge on which the n-th `tick16_i` after that edge is seen, and at that edge the line returns to idle. A tick in the same cycle as the bit start is not counted.
- R4: With `cfg_base_clk_i`=1, the pulse follows the R3 rule but counts `base_tick_i` instead of `tick16_i`.
- R5: With `cfg_low_pulse_i`=0 the pulse is high and idle is low. With `cfg_low_pulse_i`=1 the pulse is low and idle is high.
- R6: A width of n=0 produces no pulse: the line stays idle for the whole bit.
- R7: A pulse never extends past the next bit start. A new bit start restarts the count from the newly captured width, or clears it.
- R8: Data bit, enable, clock select, polarity, loopback and width are captured only on `bit_start_i`. Changes between bit starts have no effect on either output until the next bit start.
- R9: `rx_data_o` is registered and equals `ser_bit_i` when the captured loopback is 1, and `rx_pin_i` when it is 0.
- R10: Synchronous reset drives `ir_tx_o` and `rx_data_o` to 1, clears the pulse count and clears every captured field. After reset the block therefore runs in pass-through mode without loopback, and a pulse in progress at reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit_i | input | 1 | Serial bit from the UART transmitter |
| bit_start_i | input | 1 | One-cycle strobe marking the first cycle of a bit |
| tick16_i | input | 1 | One-cycle tick at 16 times the baud rate |
| base_tick_i | input | 1 | One-cycle tick of the fixed base clock |
| cfg_en_i | input | 1 | 1 = apply return-to-zero encoding |
| cfg_base_clk_i | input | 1 | 0 = width in 16x-baud ticks, 1 = width in base ticks |
| cfg_low_pulse_i | input | 1 | 0 = high pulse, 1 = low pulse |
| cfg_loop_i | input | 1 | 1 = route transmitted bit to the receive output |
| cfg_width_i | input | WIDTH_BITS | Pulse width count n |
| rx_pin_i | input | 1 | External receive pin |
| ir_tx_o | output | 1 | Encoded transmit line |
| rx_data_o | output | 1 | Receive-path data |

## Verification
Both outputs change on the same clock edge that samples the inputs causing the change. A bit start, a tick or a receive-pin value driven before edge k is therefore visible just after edge k, with no further delay. The bench drives every input on the falling edge, then computes the expected line level for the coming edge from its own count of the ticks it has driven since the bit start. It compares that value on the following falling edge. The sweep covers every combination of enable, clock select, polarity, loopback, width 0 to 15 and data bit. In base-clock mode the base tick runs unaligned to the bit, so wide counts get clipped by the next bit start. Additional passes change the configuration in mid-bit and apply reset in mid-pulse.

// File: rtl/irda_rz_pkg.sv
package irda_rz_pkg;

  // Source of the count-down tick for the pulse length.
  typedef enum logic {
    RZ_CLK_BAUD16 = 1'b0,
    RZ_CLK_BASE   = 1'b1
  } rz_clk_e;

  // Line level for a pulse flag under the chosen polarity.
  function automatic logic rz_level(input logic pulse, input logic low_pulse);
    return pulse ^ low_pulse;
  endfunction

endpackage

// File: rtl/irda_rz_shadow.sv
module irda_rz_shadow
  import irda_rz_pkg::*;
#(
  parameter int unsigned WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_start_i,
  input  logic                  data_i,
  input  logic                  en_i,
  input  rz_clk_e               clk_sel_i,
  input  logic                  low_i,
  input  logic                  loop_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  // effective values for the current edge
  output logic                  data_o,
  output logic                  en_o,
  output rz_clk_e               clk_sel_o,
  output logic                  low_o,
  output logic                  loop_o,
  output logic [WIDTH_BITS-1:0] width_o,
  // held values
  output logic                  en_q_o,
  output logic                  low_q_o
);

  logic                  data_q, en_q, low_q, loop_q;
  rz_clk_e               clk_sel_q;
  logic [WIDTH_BITS-1:0] width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= 1'b1;
      en_q      <= 1'b0;
      clk_sel_q <= RZ_CLK_BAUD16;
      low_q     <= 1'b0;
      loop_q    <= 1'b0;
      width_q   <= '0;
    end else if (bit_start_i) begin
      data_q    <= data_i;
      en_q      <= en_i;
      clk_sel_q <= clk_sel_i;
      low_q     <= low_i;
      loop_q    <= loop_i;
      width_q   <= width_i;
    end
  end

  // A bit start takes the live fields on the same edge it captures them.
  always_comb begin
    if (bit_start_i) begin
      data_o    = data_i;
      en_o      = en_i;
      clk_sel_o = clk_sel_i;
      low_o     = low_i;
      loop_o    = loop_i;
      width_o   = width_i;
    end else begin
      data_o    = data_q;
      en_o      = en_q;
      clk_sel_o = clk_sel_q;
      low_o     = low_q;
      loop_o    = loop_q;
      width_o   = width_q;
    end
  end

  assign en_q_o  = en_q;
  assign low_q_o = low_q;

  // R8: held fields change only on a bit start
  a_r8_hold_between_starts: assert property (@(posedge clk) disable iff (rst)
    !bit_start_i |=> $stable({data_q, en_q, clk_sel_q, low_q, loop_q, width_q}));

endmodule

// File: rtl/irda_rz_timer.sv
module irda_rz_timer #(
  parameter int unsigned WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_start_i,
  input  logic                  arm_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  input  logic                  tick_i,
  output logic                  pulse_next_o,
  output logic [WIDTH_BITS-1:0] remain_o
);

  logic [WIDTH_BITS-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (bit_start_i) begin
      rem_d = arm_i ? width_i : '0;
    end else if (tick_i && (rem_q != '0)) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_d;
  end

  assign pulse_next_o = (rem_d != '0);
  assign remain_o     = rem_q;

  // R6: zero width never starts a pulse
  a_r6_zero_width: assert property (@(posedge clk) disable iff (rst)
    bit_start_i && (width_i == '0) |=> rem_q == '0);

  // R2: a start that is not armed (one bit or disabled) leaves no pulse
  a_r2_unarmed_start: assert property (@(posedge clk) disable iff (rst)
    bit_start_i && !arm_i |=> rem_q == '0);

  // R3: an armed start loads the captured width
  a_r3_load_width: assert property (@(posedge clk) disable iff (rst)
    bit_start_i && arm_i |=> rem_q == $past(width_i));

  // R8: between starts the count can only fall
  a_r8_no_stretch: assert property (@(posedge clk) disable iff (rst)
    !bit_start_i |=> rem_q <= $past(rem_q));

endmodule

// File: rtl/irda_rz_line.sv
module irda_rz_line
  import irda_rz_pkg::*;
#(
  parameter logic TX_RST_LEVEL = 1'b1,
  parameter logic RX_RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic low_i,
  input  logic loop_i,
  input  logic pulse_i,
  input  logic ser_i,
  input  logic rx_pin_i,
  output logic tx_o,
  output logic rx_o
);

  logic tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= TX_RST_LEVEL;
      rx_q <= RX_RST_LEVEL;
    end else begin
      tx_q <= en_i ? rz_level(pulse_i, low_i) : ser_i;
      rx_q <= loop_i ? ser_i : rx_pin_i;
    end
  end

  assign tx_o = tx_q;
  assign rx_o = rx_q;

  // R10: both lines sit at their reset levels after a reset edge
  a_r10_reset_levels: assert property (@(posedge clk)
    $past(rst) |-> (tx_o == TX_RST_LEVEL) && (rx_o == RX_RST_LEVEL));

endmodule

// File: rtl/irda_rz_encoder.sv
module irda_rz_encoder
  import irda_rz_pkg::*;
#(
  parameter int unsigned WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_bit_i,
  input  logic                  bit_start_i,
  input  logic                  tick16_i,
  input  logic                  base_tick_i,
  input  logic                  cfg_en_i,
  input  logic                  cfg_base_clk_i,
  input  logic                  cfg_low_pulse_i,
  input  logic                  cfg_loop_i,
  input  logic [WIDTH_BITS-1:0] cfg_width_i,
  input  logic                  rx_pin_i,
  output logic                  ir_tx_o,
  output logic                  rx_data_o
);

  logic                  data_e, en_e, low_e, loop_e;
  rz_clk_e               clk_sel_e;
  logic [WIDTH_BITS-1:0] width_e;
  logic                  en_q, low_q;
  logic                  tick_sel, arm, pulse_next;
  logic [WIDTH_BITS-1:0] remain;

  irda_rz_shadow #(.WIDTH_BITS(WIDTH_BITS)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .bit_start_i(bit_start_i),
    .data_i     (ser_bit_i),
    .en_i       (cfg_en_i),
    .clk_sel_i  (rz_clk_e'(cfg_base_clk_i)),
    .low_i      (cfg_low_pulse_i),
    .loop_i     (cfg_loop_i),
    .width_i    (cfg_width_i),
    .data_o     (data_e),
    .en_o       (en_e),
    .clk_sel_o  (clk_sel_e),
    .low_o      (low_e),
    .loop_o     (loop_e),
    .width_o    (width_e),
    .en_q_o     (en_q),
    .low_q_o    (low_q)
  );

  assign tick_sel = (clk_sel_e == RZ_CLK_BASE) ? base_tick_i : tick16_i;
  assign arm      = en_e & ~data_e;

  irda_rz_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .bit_start_i (bit_start_i),
    .arm_i       (arm),
    .width_i     (width_e),
    .tick_i      (tick_sel),
    .pulse_next_o(pulse_next),
    .remain_o    (remain)
  );

  irda_rz_line #(.TX_RST_LEVEL(1'b1), .RX_RST_LEVEL(1'b1)) u_line (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_e),
    .low_i   (low_e),
    .loop_i  (loop_e),
    .pulse_i (pulse_next),
    .ser_i   (ser_bit_i),
    .rx_pin_i(rx_pin_i),
    .tx_o    (ir_tx_o),
    .rx_o    (rx_data_o)
  );

  // R2, R5: with encoding on and no count left, the line is at idle level
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    en_q && (remain == '0) |-> ir_tx_o == low_q);

  // R5: while a count is running the line is at pulse level
  a_r5_pulse_level: assert property (@(posedge clk) disable iff (rst)
    en_q && (remain != '0) |-> ir_tx_o == !low_q);

  // R1: pass-through mode copies the serial bit one cycle later
  a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
    !en_q && !$past(rst) |-> ir_tx_o == $past(ser_bit_i));

endmodule

// File: tb/tb_irda_rz_encoder.sv
`timescale 1ns/1ps
module tb_irda_rz_encoder;

  localparam int P      = 3;        // cycles per 16x tick
  localparam int Q      = 5;        // cycles per base tick
  localparam int BITLEN = 16 * P;   // cycles per bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_bit_i = 1'b1, bit_start_i = 1'b0, tick16_i = 1'b0, base_tick_i = 1'b0;
  logic       cfg_en_i = 1'b0, cfg_base_clk_i = 1'b0, cfg_low_pulse_i = 1'b0, cfg_loop_i = 1'b0;
  logic [3:0] cfg_width_i = 4'd0;
  logic       rx_pin_i = 1'b1;
  logic       ir_tx_o, rx_data_o;

  int total = 0;
  int bad   = 0;
  int gcyc  = 0;

  always #2.5 clk = ~clk;

  irda_rz_encoder #(.WIDTH_BITS(4)) dut (
    .clk(clk), .rst(rst), .ser_bit_i(ser_bit_i), .bit_start_i(bit_start_i),
    .tick16_i(tick16_i), .base_tick_i(base_tick_i), .cfg_en_i(cfg_en_i),
    .cfg_base_clk_i(cfg_base_clk_i), .cfg_low_pulse_i(cfg_low_pulse_i),
    .cfg_loop_i(cfg_loop_i), .cfg_width_i(cfg_width_i), .rx_pin_i(rx_pin_i),
    .ir_tx_o(ir_tx_o), .rx_data_o(rx_data_o)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, gcyc);
    end
  endtask

  // One full bit; called at a falling edge. mid=1 scrambles the live
  // configuration from cycle 4 on.
  task automatic run_bit(input logic en, input logic bmode, input logic low,
                         input logic loop, input int n, input logic d, input logic mid);
    int    cnt = 0;
    logic  pulse, etx, erx, tk16, tkb;
    string tag;
    for (int t = 0; t < BITLEN; t++) begin
      tk16 = (t % P == 0);
      tkb  = (gcyc % Q == 0);
      bit_start_i = (t == 0);
      ser_bit_i   = d;
      tick16_i    = tk16;
      base_tick_i = tkb;
      rx_pin_i    = gcyc[1];
      if (mid && t >= 4) begin
        cfg_en_i = ~en; cfg_base_clk_i = ~bmode; cfg_low_pulse_i = ~low;
        cfg_loop_i = ~loop; cfg_width_i = ~4'(n);
      end else begin
        cfg_en_i = en; cfg_base_clk_i = bmode; cfg_low_pulse_i = low;
        cfg_loop_i = loop; cfg_width_i = 4'(n);
      end
      if (t > 0 && (bmode ? tkb : tk16)) cnt++;
      pulse = en && !d && (cnt < n);
      etx   = en ? (pulse ^ low) : d;
      erx   = loop ? d : rx_pin_i;
      if (mid)              tag = "R8";
      else if (!en)         tag = "R1";
      else if (d)           tag = "R2";
      else if (n == 0)      tag = "R6";
      else if (bmode && n >= 11) tag = "R7";
      else if (low)         tag = "R5";
      else if (bmode)       tag = "R4";
      else                  tag = "R3";
      @(posedge clk);
      @(negedge clk);
      gcyc++;
      chk(tag, ir_tx_o, etx, "ir_tx_o");
      chk(mid ? "R8" : "R9", rx_data_o, erx, "rx_data_o");
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R10: reset state, pass-through with no loopback
    chk("R10", ir_tx_o, 1'b1, "ir_tx_o after reset");
    chk("R10", rx_data_o, 1'b1, "rx_data_o after reset");
    rx_pin_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10", rx_data_o, 1'b0, "rx_data_o follows pin after reset");
    chk("R10", ir_tx_o, 1'b1, "ir_tx_o follows serial after reset");

    // Full sweep (R1..R7, R9)
    for (int en = 0; en < 2; en++)
      for (int bm = 0; bm < 2; bm++)
        for (int lo = 0; lo < 2; lo++)
          for (int lp = 0; lp < 2; lp++)
            for (int n = 0; n < 16; n++)
              for (int d = 0; d < 2; d++)
                run_bit(en[0], bm[0], lo[0], lp[0], n, d[0], 1'b0);

    // R8: mid-bit configuration changes ignored
    run_bit(1'b1, 1'b0, 1'b0, 1'b0, 9,  1'b0, 1'b1);
    run_bit(1'b1, 1'b1, 1'b1, 1'b1, 5,  1'b0, 1'b1);
    run_bit(1'b1, 1'b0, 1'b1, 1'b0, 0,  1'b0, 1'b1);
    run_bit(1'b0, 1'b0, 1'b0, 1'b1, 7,  1'b0, 1'b1);
    run_bit(1'b1, 1'b0, 1'b0, 1'b1, 15, 1'b1, 1'b1);

    // R10: reset in mid-pulse drops the pulse
    bit_start_i = 1'b1; ser_bit_i = 1'b0; cfg_en_i = 1'b1; cfg_base_clk_i = 1'b0;
    cfg_low_pulse_i = 1'b0; cfg_loop_i = 1'b0; cfg_width_i = 4'd15; tick16_i = 1'b0;
    base_tick_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    bit_start_i = 1'b0;
    chk("R3", ir_tx_o, 1'b1, "pulse before reset");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10", ir_tx_o, 1'b1, "ir_tx_o at reset");
    rst = 1'b0;
    ser_bit_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10", ir_tx_o, 1'b1, "no pulse after reset");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule